// File: doc/BRIEF.md
# Chip-Select Wait Controller

This block sits between the bus requesters of a processor subsystem and the external bus. Each accepted request carries a 32-bit address and a flag telling memory space from I/O space. The two top address bits choose one of four 1 GB blocks. The block's active-low chip select is driven low, and the low 24 address bits go out on the external address bus. The address window therefore repeats throughout each block. The block also reports which bus cycle type the attached timing logic must run, and it closes the cycle with a one-clock done pulse.

Each block has its own programmable wait count, from 0 to 3 clocks. Once those waits have elapsed, the cycle keeps stretching for as long as the sampled ready input is low. The cycle type is normally plain SRAM. In memory space, block 0 may be switched to DRAM and block 3 to page-ROM. In I/O space, blocks 0 to 2 are external I/O. I/O block 3 is the on-chip peripheral area: it asserts no chip select and always completes in a fixed two-clock internal cycle.

The controller is built around one state machine with five states: IDLE, ADDR, WAIT, DATA and DONE. Its transitions are:

- IDLE→ADDR on an accepted request.
- ADDR→DONE for an internal I/O cycle.
- ADDR→DATA when the wait count is zero.
- ADDR→WAIT when the wait count is nonzero.
- WAIT→WAIT while waits remain.
- WAIT→DATA on the last wait.
- DATA→DATA while ready is low.
- DATA→DONE when ready is high.
- DONE→IDLE always.

Top module: `csw_ctrl`

## Requirements
- R1: After reset, all chip selects are high, the external address is 0, the cycle type is 0 (none) and done is low. The configuration resets to 3 wait clocks for every block, with DRAM and page-ROM disabled.
- R2: A request accepted in IDLE drives exactly one chip select low: cs_n_o[b], where b = addr_i[31:30]. This holds for every external cycle.
- R3: During an external cycle, ext_addr_o equals addr_i[23:0] of the accepted request. Address bits 29:24 have no effect, so the window mirrors within its block.
- R4: The cycle type uses the encoding 1 = SRAM, 2 = DRAM, 3 = page-ROM, 4 = external I/O, 5 = internal I/O. In memory space, block 0 gives 2 when DRAM is enabled, block 3 gives 3 when page-ROM is enabled, and every other case gives 1.
- R5: In I/O space, blocks 0, 1 and 2 give type 4 and assert their chip select.
- R6: In I/O space, block 3 gives type 5 and asserts no chip select. Its ext_addr_o is addr_i[7:0] with the upper bits zero, so the window repeats every 256 bytes. The cycle lasts exactly 2 clocks whatever ready_i does.
- R7: An external cycle with block wait count W and ready high lasts W+3 clocks. done_o is high in the last of those clocks only. Wait counts are loaded through cfg_we_i, with block b's count in cfg_wait_i[2b+1:2b].
- R8: Each clock that ready_i is sampled low after the programmed waits have elapsed adds one clock to the cycle. A low ready during the programmed waits adds nothing.
- R9: Chip select, external address and type appear in the first clock after acceptance. They stay constant through the cycle and return to idle values in the clock after done.
- R10: A request presented while a cycle is in progress is ignored: it neither alters the current cycle nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken only in IDLE |
| addr_i | input | 32 | Request address |
| io_i | input | 1 | 1 = I/O space, 0 = memory space |
| ready_i | input | 1 | External ready, sampled after the programmed waits |
| cfg_we_i | input | 1 | Loads the configuration inputs |
| cfg_wait_i | input | 8 | Wait count per block, 2 bits each |
| cfg_dram_i | input | 1 | Enables the DRAM type for memory block 0 |
| cfg_prom_i | input | 1 | Enables the page-ROM type for memory block 3 |
| cs_n_o | output | 4 | Active-low chip selects, one per block |
| ext_addr_o | output | 24 | External address |
| cyc_type_o | output | 3 | Bus cycle type (encoding in R4) |
| done_o | output | 1 | One-clock cycle completion pulse |

## Verification
Some properties are checked by the assertions on every clock. These are:

- At most one chip select is low at any time.
- Chip selects are held steady through a cycle and released after done.
- done is a single-clock pulse.
- DRAM and page-ROM types appear only with the chip select of block 0 and block 3 respectively.
- Internal I/O never drives a chip select.
- A low ready holds the final data clock.

Other behaviour only the bench scenarios can show. These are the exact cycle lengths for every wait count and stall length, the address mirroring and 256-byte truncation, the type chosen under each enable combination, and the rejection of a second request in mid-cycle.

// File: rtl/csw_pkg.sv
package csw_pkg;

    typedef enum logic [2:0] {
        CT_NONE  = 3'd0,
        CT_SRAM  = 3'd1,
        CT_DRAM  = 3'd2,
        CT_PROM  = 3'd3,
        CT_EXTIO = 3'd4,
        CT_INTIO = 3'd5
    } cyc_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_WAIT = 3'd2,
        ST_DATA = 3'd3,
        ST_DONE = 3'd4
    } st_t;

endpackage

// File: rtl/csw_cfg.sv
module csw_cfg #(
    parameter int NUM_BLK = 4,
    parameter int WAIT_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [NUM_BLK*WAIT_W-1:0] wait_i,
    input  logic                      dram_i,
    input  logic                      prom_i,
    output logic [NUM_BLK*WAIT_W-1:0] wait_o,
    output logic                      dram_o,
    output logic                      prom_o
);

    genvar b;
    generate
        for (b = 0; b < NUM_BLK; b++) begin : g_blk
            logic [WAIT_W-1:0] wcnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    wcnt_q <= '1;
                else if (we_i) wcnt_q <= wait_i[b*WAIT_W +: WAIT_W];
            end
            assign wait_o[b*WAIT_W +: WAIT_W] = wcnt_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dram_o <= 1'b0;
            prom_o <= 1'b0;
        end else if (we_i) begin
            dram_o <= dram_i;
            prom_o <= prom_i;
        end
    end

endmodule

// File: rtl/csw_decode.sv
module csw_decode
    import csw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int EXT_W   = 24,
    parameter int INT_W   = 8,
    parameter int NUM_BLK = 4,
    parameter int WAIT_W  = 2
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      io_i,
    input  logic [NUM_BLK*WAIT_W-1:0] wait_i,
    input  logic                      dram_en_i,
    input  logic                      prom_en_i,
    output logic [$clog2(NUM_BLK)-1:0] blk_o,
    output cyc_t                      ctype_o,
    output logic [EXT_W-1:0]          xaddr_o,
    output logic [WAIT_W-1:0]         wsel_o
);

    localparam int BLK_W   = $clog2(NUM_BLK);
    localparam int LAST_B  = NUM_BLK - 1;
    localparam int MIR_W   = ADDR_W - BLK_W - EXT_W;

    logic unused_mirror_bits;
    assign unused_mirror_bits = ^addr_i[ADDR_W-BLK_W-1 -: MIR_W];

    assign blk_o = addr_i[ADDR_W-1 -: BLK_W];

    always_comb begin
        if (io_i) begin
            ctype_o = (int'(blk_o) == LAST_B) ? CT_INTIO : CT_EXTIO;
        end else if (int'(blk_o) == 0 && dram_en_i) begin
            ctype_o = CT_DRAM;
        end else if (int'(blk_o) == LAST_B && prom_en_i) begin
            ctype_o = CT_PROM;
        end else begin
            ctype_o = CT_SRAM;
        end
    end

    always_comb begin
        if (ctype_o == CT_INTIO) begin
            xaddr_o = '0;
            xaddr_o[INT_W-1:0] = addr_i[INT_W-1:0];
            wsel_o  = '0;
        end else begin
            xaddr_o = addr_i[EXT_W-1:0];
            wsel_o  = wait_i[blk_o*WAIT_W +: WAIT_W];
        end
    end

endmodule

// File: rtl/csw_fsm.sv
module csw_fsm
    import csw_pkg::*;
#(
    parameter int EXT_W   = 24,
    parameter int NUM_BLK = 4,
    parameter int WAIT_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_i,
    input  logic                       ready_i,
    input  logic [$clog2(NUM_BLK)-1:0] blk_i,
    input  cyc_t                       ctype_i,
    input  logic [EXT_W-1:0]           xaddr_i,
    input  logic [WAIT_W-1:0]          wsel_i,
    output logic [NUM_BLK-1:0]         cs_n_o,
    output logic [EXT_W-1:0]           ext_addr_o,
    output logic [2:0]                 cyc_type_o,
    output logic                       done_o
);

    localparam int BLK_W  = $clog2(NUM_BLK);
    localparam int LAST_B = NUM_BLK - 1;

    st_t               state_q, state_d;
    logic [BLK_W-1:0]  blk_q;
    cyc_t              ctype_q;
    logic [EXT_W-1:0]  xaddr_q;
    logic [WAIT_W-1:0] wcnt_q, wcnt_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        unique case (state_q)
            ST_IDLE: if (req_i) begin
                state_d = ST_ADDR;
                wcnt_d  = wsel_i;
            end
            ST_ADDR: begin
                if (ctype_q == CT_INTIO)  state_d = ST_DONE;
                else if (wcnt_q == '0)    state_d = ST_DATA;
                else                      state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (wcnt_q == WAIT_W'(1)) state_d = ST_DATA;
                wcnt_d = wcnt_q - WAIT_W'(1);
            end
            ST_DATA: if (ready_i) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            blk_q   <= '0;
            ctype_q <= CT_NONE;
            xaddr_q <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            if (state_q == ST_IDLE && req_i) begin
                blk_q   <= blk_i;
                ctype_q <= ctype_i;
                xaddr_q <= xaddr_i;
            end
        end
    end

    // Outputs
    always_comb begin
        cs_n_o     = '1;
        ext_addr_o = '0;
        cyc_type_o = CT_NONE;
        done_o     = 1'b0;
        if (state_q != ST_IDLE) begin
            ext_addr_o = xaddr_q;
            cyc_type_o = ctype_q;
            if (ctype_q != CT_INTIO) cs_n_o[blk_q] = 1'b0;
            done_o = (state_q == ST_DONE);
        end
    end

    a_r2_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    a_r9_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o != '1 && !done_o) |=> (cs_n_o == $past(cs_n_o)));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (cs_n_o == '1 && cyc_type_o == 3'd0));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r4_dram_blk0: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type_o == 3'd2) |-> !cs_n_o[0]);

    a_r4_prom_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type_o == 3'd3) |-> !cs_n_o[LAST_B]);

    a_r6_int_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type_o == 3'd5) |-> (cs_n_o == '1));

    a_r8_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !ready_i) |=> (!done_o && cs_n_o == $past(cs_n_o)));

endmodule

// File: rtl/csw_ctrl.sv
module csw_ctrl
    import csw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int EXT_W   = 24,
    parameter int INT_W   = 8,
    parameter int NUM_BLK = 4,
    parameter int WAIT_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      io_i,
    input  logic                      ready_i,
    input  logic                      cfg_we_i,
    input  logic [NUM_BLK*WAIT_W-1:0] cfg_wait_i,
    input  logic                      cfg_dram_i,
    input  logic                      cfg_prom_i,
    output logic [NUM_BLK-1:0]        cs_n_o,
    output logic [EXT_W-1:0]          ext_addr_o,
    output logic [2:0]                cyc_type_o,
    output logic                      done_o
);

    localparam int BLK_W = $clog2(NUM_BLK);

    logic [NUM_BLK*WAIT_W-1:0] wait_cfg;
    logic                      dram_en, prom_en;
    logic [BLK_W-1:0]          dec_blk;
    cyc_t                      dec_type;
    logic [EXT_W-1:0]          dec_xaddr;
    logic [WAIT_W-1:0]         dec_wait;

    csw_cfg #(.NUM_BLK(NUM_BLK), .WAIT_W(WAIT_W)) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .wait_i (cfg_wait_i),
        .dram_i (cfg_dram_i),
        .prom_i (cfg_prom_i),
        .wait_o (wait_cfg),
        .dram_o (dram_en),
        .prom_o (prom_en)
    );

    csw_decode #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .INT_W(INT_W),
                 .NUM_BLK(NUM_BLK), .WAIT_W(WAIT_W)) dec_i (
        .addr_i    (addr_i),
        .io_i      (io_i),
        .wait_i    (wait_cfg),
        .dram_en_i (dram_en),
        .prom_en_i (prom_en),
        .blk_o     (dec_blk),
        .ctype_o   (dec_type),
        .xaddr_o   (dec_xaddr),
        .wsel_o    (dec_wait)
    );

    csw_fsm #(.EXT_W(EXT_W), .NUM_BLK(NUM_BLK), .WAIT_W(WAIT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .ready_i    (ready_i),
        .blk_i      (dec_blk),
        .ctype_i    (dec_type),
        .xaddr_i    (dec_xaddr),
        .wsel_i     (dec_wait),
        .cs_n_o     (cs_n_o),
        .ext_addr_o (ext_addr_o),
        .cyc_type_o (cyc_type_o),
        .done_o     (done_o)
    );

endmodule

// File: tb/csw_ctrl_tb_top.sv
`timescale 1ns/1ps
module csw_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        io_i = 1'b0;
    logic        ready_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [7:0]  cfg_wait_i = '0;
    logic        cfg_dram_i = 1'b0;
    logic        cfg_prom_i = 1'b0;
    logic [3:0]  cs_n_o;
    logic [23:0] ext_addr_o;
    logic [2:0]  cyc_type_o;
    logic        done_o;

    int n_checks = 0;
    int n_errs   = 0;
    int m_wait [4] = '{3, 3, 3, 3};
    bit m_dram = 0;
    bit m_prom = 0;

    always #4 clk = ~clk;

    csw_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .io_i(io_i),
        .ready_i(ready_i), .cfg_we_i(cfg_we_i), .cfg_wait_i(cfg_wait_i),
        .cfg_dram_i(cfg_dram_i), .cfg_prom_i(cfg_prom_i), .cs_n_o(cs_n_o),
        .ext_addr_o(ext_addr_o), .cyc_type_o(cyc_type_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cfg_write(input int w0, input int w1, input int w2, input int w3,
                             input bit de, input bit pe);
        @(negedge clk);
        cfg_wait_i = {w3[1:0], w2[1:0], w1[1:0], w0[1:0]};
        cfg_dram_i = de;
        cfg_prom_i = pe;
        cfg_we_i   = 1'b1;
        @(negedge clk);
        cfg_we_i   = 1'b0;
        m_wait = '{w0, w1, w2, w3};
        m_dram = de;
        m_prom = pe;
    endtask

    // One bus cycle; every clock is compared against the model until two idle clocks follow it
    task automatic run_one(input logic [31:0] a, input bit io, input int stall, input bit extra);
        int blk, et, w, len;
        bit act;
        logic [23:0] ea;
        logic [3:0]  ecs;
        string ttag, ltag;
        blk = int'(a[31:30]);
        if (io) et = (blk == 3) ? 5 : 4;
        else if (blk == 0 && m_dram) et = 2;
        else if (blk == 3 && m_prom) et = 3;
        else et = 1;
        w   = (et == 5) ? 0 : m_wait[blk];
        len = (et == 5) ? 2 : w + 3 + stall;
        ea  = (et == 5) ? {16'h0, a[7:0]} : a[23:0];
        ecs = (et == 5) ? 4'hF : ~(4'b1 << blk);
        ttag = (et == 5) ? "R6" : (io ? "R5" : "R4");
        ltag = (et == 5) ? "R6" : (stall > 0 ? "R8" : "R7");
        @(negedge clk);
        req_i = 1'b1; addr_i = a; io_i = io; ready_i = 1'b1;
        for (int n = 1; n <= len + 2; n++) begin
            @(negedge clk);
            act = (n <= len);
            // R2 chip select, R9 held then released, R10 second request ignored
            chk(extra ? "R10" : "R2", "cs_n", int'(cs_n_o), act ? int'(ecs) : 4'hF);
            chk(extra ? "R10" : "R3", "ext_addr", int'(ext_addr_o), act ? int'(ea) : 0);
            chk(ttag, "cyc_type", int'(cyc_type_o), act ? et : 0);
            chk(ltag, "done", int'(done_o), (n == len) ? 1 : 0);
            if (n == 1 && extra) begin
                req_i  = 1'b1;
                addr_i = a ^ 32'h4012_3456;
                io_i   = ~io;
            end else begin
                req_i  = 1'b0;
            end
            ready_i = (stall == 0) ? 1'b1 : (n > w + 1 + stall);
        end
        ready_i = 1'b1;
        io_i = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n", int'(cs_n_o), 4'hF);
        chk("R1", "ext_addr", int'(ext_addr_o), 0);
        chk("R1", "cyc_type", int'(cyc_type_o), 0);
        chk("R1", "done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cs_n after release", int'(cs_n_o), 4'hF);
        // R1 default configuration: 3 waits, SRAM everywhere
        run_one(32'h0012_3456, 1'b0, 0, 1'b0);
        run_one(32'hC0AB_CDEF, 1'b0, 1, 1'b0);
        run_one(32'hC7FF_FF12, 1'b1, 0, 1'b0);

        for (int rot = 0; rot < 4; rot++) begin
            for (int cfgc = 0; cfgc < 4; cfgc++) begin
                cfg_write(rot % 4, (1 + rot) % 4, (2 + rot) % 4, (3 + rot) % 4,
                          cfgc[0], cfgc[1]);
                for (int b = 0; b < 4; b++) begin
                    for (int io = 0; io < 2; io++) begin
                        for (int s = 0; s < 3; s += 2) begin
                            logic [31:0] a;
                            a[31:30] = 2'(b);
                            a[29:24] = 6'(rot * 13 + b * 5 + cfgc + s);
                            a[23:0]  = 24'(32'h05A3C1 * (b + 1 + rot) + cfgc * 32'h1111 + io);
                            run_one(a, io[0], s, (b == rot) && (s == 0));
                        end
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule